// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block is the read-side sequencer of a synchronous burst memory. A host writes a 16-bit configuration word and then, on a chosen edge of its burst clock, presents a start address together with an address-latch strobe. From then on, every active edge of the burst clock produces one array word address and a data-valid flag. A fixed-length burst stops and raises a done flag. A continuous burst runs until chip-enable drops.

The configuration selects three things: which edge of the burst clock is active, the burst length (4, 8, 16 words or continuous), and whether a fixed-length burst rolls over inside its aligned block or counts straight on. When a burst that counts straight on starts off an 8-word row boundary, the block raises WAIT for a fixed number of active edges the first time the sequence enters a new row. This models the internal delay the array needs to open the next row. The burst clock is oversampled by the system clock, so all state is kept in one synchronous domain.

Top module: `burst_read_seq`

## Requirements
- R1: The configuration register resets to 0x0047. A write stores every bit except bits 14, 5 and 4, which always read back as 0. After writing 0xFFFF the register reads 0xBFCF.
- R2: Configuration bit 6 picks the active burst-clock edge: 1 selects rising and 0 selects falling. An edge of the other direction leaves address, data-valid, WAIT and done unchanged.
- R3: An address-latch strobe seen on an active edge while chip-enable is high starts a burst. After that edge the array address equals the start address and data-valid is 1.
- R4: Configuration bits 2..0 set the burst length. Code 001 gives 4 words, 010 gives 8 words and 011 gives 16 words. Code 111 and every other code give a continuous burst.
- R5: With bit 3 at 0 and a fixed length, each further active edge advances the address by one inside the aligned block of the burst length. The address rolls from the top of the block to its base.
- R6: With bit 3 at 1 and a fixed length, each active edge advances the address by one across block boundaries.
- R7: In a continuous or no-wrap burst whose start address has its low three bits at 0, WAIT never rises.
- R8: In a continuous or no-wrap burst whose start address has nonzero low three bits, WAIT is 1 and data-valid is 0 for exactly 2 active edges, with the address held. This happens at the first edge whose next word would have low three bits of 0. The next active edge then emits that word. WAIT rises at most once per burst.
- R9: On the first active edge after the last word of a fixed-length burst, data-valid drops and burst-done rises with the address held. Done stays high until a new burst starts or chip-enable drops.
- R10: A clock cycle with chip-enable low clears data-valid, WAIT and done at the next system clock edge. Later active edges change nothing until a new address-latch strobe.
- R11: A wrapping fixed-length burst never raises WAIT, whatever its start address.
- R12: After reset, data-valid, WAIT and burst-done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_k | input | 1 | Host burst clock, slower than clk |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| chip_en | input | 1 | Chip enable, active high; low ends any burst |
| adv | input | 1 | Address-latch strobe, sampled on active edges |
| start_addr | input | 24 | Burst start word address |
| arr_addr | output | 24 | Current array word address |
| data_valid | output | 1 | Word at arr_addr is valid |
| wait_o | output | 1 | Host must stall; no word this edge |
| burst_done | output | 1 | Fixed-length burst completed |

## Verification
The bench starts bursts at addresses just below a block or row boundary. A design that wrapped by the wrong block size, or that did not wrap at all, would give the wrong address on the edge after the boundary. Unaligned no-wrap and continuous bursts are driven far enough to cross a second row boundary, which would expose a WAIT that fires again, lasts the wrong number of edges, moves the address during the stall or drops the delayed word. An unaligned wrapping burst exposes a WAIT that ignores the mode. Burst-clock edges of the unselected direction, a chip-enable drop in mid-burst and an unused length code expose a sequencer that steps on the wrong edge, keeps running, or reads a spare code as a fixed length.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CFG_W      = 16;
  localparam int EDGE_BIT   = 6;
  localparam int NOWRAP_BIT = 3;
  localparam logic [CFG_W-1:0] RSVD_MASK = 16'h4030;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0047;

  typedef enum logic [1:0] {BL_4, BL_8, BL_16, BL_CONT} blen_e;

  function automatic blen_e decode_blen(input logic [2:0] code);
    case (code)
      3'b001:  return BL_4;
      3'b010:  return BL_8;
      3'b011:  return BL_16;
      default: return BL_CONT;
    endcase
  endfunction

  function automatic logic [4:0] blen_words(input blen_e b);
    case (b)
      BL_4:    return 5'd4;
      BL_8:    return 5'd8;
      BL_16:   return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [2:0] blen_wrap_bits(input blen_e b);
    case (b)
      BL_4:    return 3'd2;
      BL_8:    return 3'd3;
      BL_16:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             rise_sel,
  output logic             nowrap,
  output blen_e            blen
);
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata & ~RSVD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign rdata    = cfg_q;
  assign rise_sel = cfg_q[EDGE_BIT];
  assign nowrap   = cfg_q[NOWRAP_BIT];
  assign blen     = decode_blen(cfg_q[2:0]);

  // R1
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((rdata & ~RSVD_MASK) == ($past(wdata) & ~RSVD_MASK)));
endmodule

// File: rtl/brs_edge_tick.sv
module brs_edge_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_k,
  input  logic rise_sel,
  output logic tick
);
  logic [SYNC_STAGES-1:0] k_pipe;
  logic                   k_new, k_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_pipe <= '0;
    else        k_pipe <= {k_pipe[SYNC_STAGES-2:0], host_k};
  end

  assign k_new = k_pipe[SYNC_STAGES-2];
  assign k_old = k_pipe[SYNC_STAGES-1];
  assign tick  = rise_sel ? (k_new & ~k_old) : (~k_new & k_old);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || !$stable(rise_sel)));
endmodule

// File: rtl/brs_addr_seq.sv
module brs_addr_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ROW_WORDS   = 8,
  parameter int STALL_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              chip_en,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              cfg_nowrap,
  input  blen_e             cfg_blen,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dv_o,
  output logic              wait_o,
  output logic              done_o
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);
  localparam int STALL_W  = $clog2(STALL_EDGES + 1);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dv_q, dv_d, wait_q, wait_d, done_q, done_d;
  logic [4:0]        cnt_q, cnt_d;
  logic [STALL_W-1:0] stall_q, stall_d;
  logic              waited_q, waited_d, needw_q, needw_d, wrap_q, wrap_d;
  blen_e             len_q, len_d;

  logic              start_go, fixed, start_wrap;
  logic [ADDR_W-1:0] wmask, inc, nxt;
  logic [4:0]        cnt_step;

  assign start_go   = chip_en && tick && adv;
  assign start_wrap = !cfg_nowrap && (cfg_blen != BL_CONT);
  assign fixed      = (len_q != BL_CONT);
  assign cnt_step   = fixed ? cnt_q + 5'd1 : cnt_q;

  always_comb begin
    wmask = (ADDR_W'(1) << blen_wrap_bits(len_q)) - ADDR_W'(1);
    inc   = addr_q + ADDR_W'(1);
    nxt   = wrap_q ? ((addr_q & ~wmask) | (inc & wmask)) : inc;
  end

  always_comb begin
    active_d = active_q;
    addr_d   = addr_q;
    dv_d     = dv_q;
    wait_d   = wait_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    stall_d  = stall_q;
    waited_d = waited_q;
    needw_d  = needw_q;
    wrap_d   = wrap_q;
    len_d    = len_q;
    if (!chip_en) begin
      active_d = 1'b0;
      dv_d     = 1'b0;
      wait_d   = 1'b0;
      done_d   = 1'b0;
      stall_d  = '0;
    end else if (start_go) begin
      active_d = 1'b1;
      addr_d   = start_addr;
      dv_d     = 1'b1;
      wait_d   = 1'b0;
      done_d   = 1'b0;
      cnt_d    = 5'd1;
      stall_d  = '0;
      waited_d = 1'b0;
      len_d    = cfg_blen;
      wrap_d   = start_wrap;
      needw_d  = !start_wrap && (start_addr[ROW_BITS-1:0] != '0);
    end else if (tick && active_q) begin
      if (stall_q != '0) begin
        if (stall_q == STALL_W'(1)) begin
          addr_d  = nxt;
          dv_d    = 1'b1;
          wait_d  = 1'b0;
          cnt_d   = cnt_step;
          stall_d = '0;
        end else begin
          stall_d = stall_q - STALL_W'(1);
        end
      end else if (fixed && (cnt_q == blen_words(len_q))) begin
        active_d = 1'b0;
        dv_d     = 1'b0;
        done_d   = 1'b1;
      end else if (needw_q && !waited_q && (nxt[ROW_BITS-1:0] == '0)) begin
        wait_d   = 1'b1;
        dv_d     = 1'b0;
        stall_d  = STALL_W'(STALL_EDGES);
        waited_d = 1'b1;
      end else begin
        addr_d = nxt;
        dv_d   = 1'b1;
        cnt_d  = cnt_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      dv_q     <= 1'b0;
      wait_q   <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      stall_q  <= '0;
      waited_q <= 1'b0;
      needw_q  <= 1'b0;
      wrap_q   <= 1'b0;
      len_q    <= BL_CONT;
    end else begin
      active_q <= active_d;
      addr_q   <= addr_d;
      dv_q     <= dv_d;
      wait_q   <= wait_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
      stall_q  <= stall_d;
      waited_q <= waited_d;
      needw_q  <= needw_d;
      wrap_q   <= wrap_d;
      len_q    <= len_d;
    end
  end

  assign addr_o = addr_q;
  assign dv_o   = dv_q;
  assign wait_o = wait_q;
  assign done_o = done_q;

  logic wait_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wait_seen_q <= 1'b0;
    else if (start_go) wait_seen_q <= 1'b0;
    else if (wait_q)   wait_seen_q <= 1'b1;
  end

  // R8
  wait_dv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_q && dv_q));
  // R8
  wait_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> !wait_seen_q);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && $past(wait_q)) |-> $stable(addr_q));
  // R9
  done_dv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && dv_q));
  // R10
  ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (!dv_q && !wait_q && !done_q));
  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !tick) |=> ($stable(addr_q) && $stable(dv_q) && $stable(wait_q)));
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ROW_WORDS   = 8,
  parameter int STALL_EDGES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_k,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              chip_en,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              data_valid,
  output logic              wait_o,
  output logic              burst_done
);
  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  logic       rise_sel, nowrap, tick;
  blen_e      blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  brs_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .rise_sel(rise_sel), .nowrap(nowrap), .blen(blen)
  );

  brs_edge_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n_sync), .host_k(host_k), .rise_sel(rise_sel), .tick(tick)
  );

  brs_addr_seq #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS), .STALL_EDGES(STALL_EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .chip_en(chip_en), .adv(adv),
    .start_addr(start_addr), .cfg_nowrap(nowrap), .cfg_blen(blen),
    .addr_o(arr_addr), .dv_o(data_valid), .wait_o(wait_o), .done_o(burst_done)
  );
endmodule

// File: tb/sim_burst_read_seq.sv
`timescale 1ns/1ps
module sim_burst_read_seq;
  logic        clk = 1'b0;
  logic        rst_n, host_k, cfg_we, chip_en, adv;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [23:0] start_addr, arr_addr;
  logic        data_valid, wait_o, burst_done;
  logic        edge_rise;
  int          n_checks = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  burst_read_seq u0 (
    .clk(clk), .rst_n(rst_n), .host_k(host_k), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .chip_en(chip_en), .adv(adv), .start_addr(start_addr),
    .arr_addr(arr_addr), .data_valid(data_valid), .wait_o(wait_o), .burst_done(burst_done)
  );

  task automatic chk(input string tag, input logic [26:0] act, input logic [26:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got addr/dv/wait/done %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic active_edge();
    @(negedge clk);
    host_k = edge_rise ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    host_k = edge_rise;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(input logic [15:0] cfg, input logic [23:0] sa,
                         input int nticks, input string tag);
    int len, stall, emitted;
    bit wrapm, needw, waited, fin;
    logic [23:0] cur, nx, msk;
    logic [26:0] exp;
    write_cfg(cfg);
    edge_rise = cfg[6];
    case (cfg[2:0])
      3'b001:  len = 4;
      3'b010:  len = 8;
      3'b011:  len = 16;
      default: len = 0;
    endcase
    wrapm = !cfg[3] && (len != 0);
    msk   = wrapm ? 24'(len - 1) : 24'd0;
    needw = !wrapm && (sa[2:0] != 3'd0);
    chip_en = 1'b1;
    start_addr = sa;
    adv = 1'b1;
    active_edge();
    adv = 1'b0;
    cur = sa; emitted = 1; stall = 0; waited = 0; fin = 0;
    chk({tag, " start (R3)"}, {arr_addr, data_valid, wait_o, burst_done}, {sa, 3'b100});
    for (int i = 1; i < nticks; i++) begin
      active_edge();
      nx = wrapm ? ((cur & ~msk) | ((cur + 24'd1) & msk)) : cur + 24'd1;
      if (fin) exp = {cur, 3'b001};
      else if (stall > 0) begin
        stall--;
        if (stall == 0) begin cur = nx; emitted++; exp = {cur, 3'b100}; end
        else exp = {cur, 3'b010};
      end else if (len != 0 && emitted == len) begin
        fin = 1; exp = {cur, 3'b001};
      end else if (needw && !waited && nx[2:0] == 3'd0) begin
        waited = 1; stall = 2; exp = {cur, 3'b010};
      end else begin
        cur = nx; emitted++; exp = {cur, 3'b100};
      end
      chk(tag, {arr_addr, data_valid, wait_o, burst_done}, exp);
    end
  endtask

  task automatic t_reset();
    chk("R12 reset outputs", {24'd0, data_valid, wait_o, burst_done}, 27'd0);
    chk("R1 reset cfg", {11'd0, cfg_rdata}, {11'd0, 16'h0047});
  endtask

  task automatic t_cfg_rsvd();
    write_cfg(16'hFFFF);
    @(negedge clk);
    chk("R1 reserved masked", {11'd0, cfg_rdata}, {11'd0, 16'hBFCF});
    write_cfg(16'h0000);
    @(negedge clk);
    chk("R1 cleared", {11'd0, cfg_rdata}, 27'd0);
  endtask

  task automatic t_edge_sel();
    write_cfg(16'h0007);
    edge_rise = 1'b0;
    chip_en = 1'b1;
    start_addr = 24'h10;
    adv = 1'b1;
    active_edge();
    adv = 1'b0;
    chk("R2 falling start", {arr_addr, data_valid, wait_o, burst_done}, {24'h10, 3'b100});
    @(negedge clk);
    host_k = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 rising ignored", {arr_addr, data_valid, wait_o, burst_done}, {24'h10, 3'b100});
    active_edge();
    chk("R2 falling advances", {arr_addr, data_valid, wait_o, burst_done}, {24'h11, 3'b100});
  endtask

  task automatic t_chip_en();
    run_seq(16'h0047, 24'h20, 3, "R10 pre");
    @(negedge clk);
    chip_en = 1'b0;
    @(negedge clk);
    chip_en = 1'b1;
    chk("R10 drop", {24'd0, data_valid, wait_o, burst_done}, 27'd0);
    active_edge();
    chk("R10 idle after drop", {24'd0, data_valid, wait_o, burst_done}, 27'd0);
    start_addr = 24'h77;
    adv = 1'b1;
    active_edge();
    adv = 1'b0;
    chk("R3 restart", {arr_addr, data_valid, wait_o, burst_done}, {24'h77, 3'b100});
  endtask

  initial begin
    rst_n = 1'b0; host_k = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    chip_en = 1'b0; adv = 1'b0; start_addr = '0; edge_rise = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_cfg_rsvd();
    run_seq(16'h0041, 24'h000106, 7, "R5 wrap4 R9");
    run_seq(16'h0002, 24'h00000D, 10, "R5 wrap8 falling R2");
    t_edge_sel();
    run_seq(16'h004B, 24'h00001D, 22, "R8 nowrap16 R6 R9");
    run_seq(16'h004A, 24'h000005, 12, "R6 nowrap8 R8");
    run_seq(16'h0047, 24'h000038, 20, "R7 continuous aligned R4");
    run_seq(16'h0044, 24'h00003E, 24, "R8 spare code continuous R4");
    run_seq(16'h0043, 24'h00000B, 19, "R11 wrap16 unaligned R5");
    t_chip_en();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule